// File: doc/BRIEF.md
# PWM Auto-Reload Timer

This block is an 8-bit up-counting timer with four pulse-width-modulated outputs. A 7-bit binary prescaler divides the selected input clock by a power of two from 1 to 128, and each prescaler tick advances the counter by one. When the counter passes its maximum value it restarts from a programmable reload value rather than from zero. The PWM period is therefore (256 - reload) x 2^n input ticks.

Each output channel has a duty-cycle register that software writes and a hidden compare register. The compare register copies the duty value only at overflow, so a duty change made mid-period cannot glitch the waveform. An output goes high at overflow and goes low when the counter reaches that channel's compare value.

The input clock is either the system clock or an external pin. The pin passes through a two-flop synchronizer, and its rising edges become single-cycle advance enables, so the whole block runs in one clock domain. Software reaches the block through a write strobe, an address and a combinational read-data bus. Address 0 is control, 1 is reload, 2 is counter access, and 3 to 6 are the duty registers of channels 0 to 3.

Top module: `pwm_reload_timer`

## Requirements
- R1: While the run bit (control bit 3) is set, the counter rises by exactly one every 2^n source ticks, where n is control bits [2:0].
- R2: An advance from FFh loads the counter with the reload register (address 1), not 00h, so overflows repeat every (256 - reload) x 2^n source ticks.
- R3: While the run bit is clear, the counter and the prescaler both hold their values.
- R4: With control bit 4 set, the source tick is a rising edge of `ext_clk_i` after a two-flop synchronizer, and the counter does not advance while the pin is steady.
- R5: A write to address 2 loads the counter with the written value and clears the prescaler, so the next advance comes a full 2^n source ticks later.
- R6: Writing control with bit 5 set loads the counter from the reload register and clears the prescaler; bit 5 is not stored and reads back as 0.
- R7: A channel's compare value copies its duty register (addresses 3 to 6 for channels 0 to 3) only at overflow; a duty write mid-period affects the next period.
- R8: Each output goes high at overflow and goes low when the counter reaches its compare value D, so for reload < D <= FFh it is high for (D - reload) x 2^n source ticks per period.
- R9: A channel whose compare value is less than or equal to the reload value stays high for the whole period.
- R10: After reset the counter, the prescaler and all registers are zero, the system clock is the source, and every output is low until the first overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count source, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pwm_o | output | 4 | PWM outputs, channel 0 in bit 0 |

## Verification
The bench uses the default parameters: an 8-bit counter, a 7-bit prescaler, four channels and two synchronizer stages. With these defaults every tap from divide-by-1 to divide-by-128 is reachable, and so is a full 256-count period from reload 00h, all in a few hundred cycles each. All four channels can be placed side by side to cover a compare value equal to the reload value, one below it, and one at FFh.

// File: rtl/prt_pkg.sv
package prt_pkg;
   // register map
   localparam int ADR_CTRL   = 0;
   localparam int ADR_RELOAD = 1;
   localparam int ADR_COUNT  = 2;
   localparam int ADR_DUTY0  = 3;

   typedef enum logic {
      SRC_SYS = 1'b0,
      SRC_EXT = 1'b1
   } prt_src_e;
endpackage

// File: rtl/prt_edge_sync.sv
module prt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad
         $error("prt_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[LAST];
      end
   end

   assign rise_o = sync_q[LAST] & ~last_q;
endmodule

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
   parameter int PRE_W = 7,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             src_tick,
   input  logic             clr,
   input  logic [SEL_W-1:0] tap,
   output logic             adv
);
   generate
      if (PRE_W < 1) begin : g_bad
         $error("prt_prescaler: PRE_W must be positive");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] low_mask;

   // bits below the tap must all be ones for the carry to reach the tap
   assign low_mask = ~({PRE_W{1'b1}} << tap);
   assign adv      = run & src_tick & (&(pre_q | ~low_mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clr)
         pre_q <= '0;
      else if (run && src_tick)
         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_direct,
   input  logic         ld_reload,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] reload,
   input  logic         adv,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_nxt,
   output logic         ovf,
   output logic         step
);
   localparam logic [W-1:0] TOP = '1;

   always_comb begin
      ovf     = 1'b0;
      step    = 1'b0;
      cnt_nxt = cnt_q;
      if (ld_direct)
         cnt_nxt = ld_val;
      else if (ld_reload)
         cnt_nxt = reload;
      else if (adv) begin
         if (cnt_q == TOP) begin
            ovf     = 1'b1;
            cnt_nxt = reload;
         end else begin
            step    = 1'b1;
            cnt_nxt = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/prt_channel.sv
module prt_channel #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ovf,
   input  logic         step,
   input  logic [W-1:0] cnt_nxt,
   input  logic [W-1:0] duty,
   output logic [W-1:0] cmp_q,
   output logic         pwm_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         pwm_q <= 1'b0;
      end else if (ovf) begin
         cmp_q <= duty;
         pwm_q <= 1'b1;
      end else if (step && (cnt_nxt == cmp_q)) begin
         pwm_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
   parameter int CNT_W       = 8,
   parameter int PRE_W       = 7,
   parameter int NUM_CH      = 4,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_clk_i,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] pwm_o
);
   import prt_pkg::*;

   localparam int SEL_W   = $clog2(PRE_W + 1);
   localparam int RUN_BIT = SEL_W;
   localparam int EXT_BIT = SEL_W + 1;
   localparam int FRC_BIT = SEL_W + 2;

   generate
      if (FRC_BIT >= CNT_W) begin : g_bad_ctrl
         $error("pwm_reload_timer: control fields do not fit CNT_W");
      end
      if (ADR_DUTY0 + NUM_CH > (1 << ADDR_W)) begin : g_bad_addr
         $error("pwm_reload_timer: ADDR_W too small for NUM_CH");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("pwm_reload_timer: NUM_CH must be positive");
      end
   endgenerate

   // register state
   logic [SEL_W-1:0]  tap_q;
   logic              run_q;
   prt_src_e          src_q;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  duty_q [NUM_CH];

   logic wr_ctrl, wr_count, frc;
   assign wr_ctrl  = bus_wr && (int'(bus_addr) == ADR_CTRL);
   assign wr_count = bus_wr && (int'(bus_addr) == ADR_COUNT);
   assign frc      = wr_ctrl && bus_wdata[FRC_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q    <= '0;
         run_q    <= 1'b0;
         src_q    <= SRC_SYS;
         reload_q <= '0;
      end else if (bus_wr) begin
         if (int'(bus_addr) == ADR_CTRL) begin
            tap_q <= bus_wdata[SEL_W-1:0];
            run_q <= bus_wdata[RUN_BIT];
            src_q <= prt_src_e'(bus_wdata[EXT_BIT]);
         end
         if (int'(bus_addr) == ADR_RELOAD)
            reload_q <= bus_wdata;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_duty
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               duty_q[gi] <= '0;
            else if (bus_wr && (int'(bus_addr) == ADR_DUTY0 + gi))
               duty_q[gi] <= bus_wdata;
         end
      end
   endgenerate

   // count source
   logic ext_rise, src_tick, adv, cnt_ld;
   prt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_clk_i),
      .rise_o  (ext_rise)
   );
   assign src_tick = (src_q == SRC_EXT) ? ext_rise : 1'b1;
   assign cnt_ld   = wr_count | frc;

   prt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .src_tick (src_tick),
      .clr      (cnt_ld),
      .tap      (tap_q),
      .adv      (adv)
   );

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             ovf, step;
   prt_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_direct (wr_count),
      .ld_reload (frc),
      .ld_val    (bus_wdata),
      .reload    (reload_q),
      .adv       (adv),
      .cnt_q     (cnt_q),
      .cnt_nxt   (cnt_nxt),
      .ovf       (ovf),
      .step      (step)
   );

   // compare channels
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_w;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         prt_channel #(.W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ovf     (ovf),
            .step    (step),
            .cnt_nxt (cnt_nxt),
            .duty    (duty_q[gi]),
            .cmp_q   (cmp_w[gi]),
            .pwm_q   (pwm_o[gi])
         );
      end
   endgenerate

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (int'(bus_addr) == ADR_CTRL) begin
         bus_rdata[SEL_W-1:0] = tap_q;
         bus_rdata[RUN_BIT]   = run_q;
         bus_rdata[EXT_BIT]   = (src_q == SRC_EXT);
      end else if (int'(bus_addr) == ADR_RELOAD)
         bus_rdata = reload_q;
      else if (int'(bus_addr) == ADR_COUNT)
         bus_rdata = cnt_q;
      else begin
         for (int k = 0; k < NUM_CH; k++)
            if (int'(bus_addr) == ADR_DUTY0 + k)
               bus_rdata = duty_q[k];
      end
   end
endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk #(
   parameter int CNT_W  = 8,
   parameter int NUM_CH = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [CNT_W-1:0]             cnt_q,
   input logic [CNT_W-1:0]             reload_q,
   input logic                         ovf,
   input logic                         step,
   input logic                         cnt_ld,
   input logic                         run_q,
   input logic [NUM_CH-1:0][CNT_W-1:0] cmp_w,
   input logic [NUM_CH-1:0]            pwm_o
);
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1

   AST_WRAP_TO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> cnt_q == $past(reload_q)); // R2

   AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cnt_ld) |=> $stable(cnt_q)); // R3

   AST_CMP_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf |=> $stable(cmp_w)); // R7

   AST_OUT_HIGH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> &pwm_o); // R8
endmodule

bind pwm_reload_timer pwm_reload_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_q    (cnt_q),
   .reload_q (reload_q),
   .ovf      (ovf),
   .step     (step),
   .cnt_ld   (cnt_ld),
   .run_q    (run_q),
   .cmp_w    (cmp_w),
   .pwm_o    (pwm_o)
);

// File: tb/sim_pwm_reload_timer.sv
module sim_pwm_reload_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_clk_i = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] pwm_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pwm_reload_timer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_clk_i (ext_clk_i),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_o     (pwm_o)
   );

   // {reload, tap, duty0}
   localparam logic [23:0] VEC [6] = '{
      {8'hF0, 8'd0, 8'hF8},
      {8'hC0, 8'd1, 8'hE0},
      {8'hFC, 8'd3, 8'hFE},
      {8'h00, 8'd0, 8'h80},
      {8'hE0, 8'd2, 8'hF0},
      {8'hFE, 8'd7, 8'hFF}
   };

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      bus_addr  = 3'(a);
      bus_wdata = 8'(d);
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      bus_addr = 3'(a);
      #1;
      d = int'(bus_rdata);
   endtask

   function automatic int ctl(input int tap, input int run, input int ext, input int frc);
      return tap | (run << 3) | (ext << 4) | (frc << 5);
   endfunction

   task automatic count_level(input int ch, input logic lvl, output int n);
      n = 0;
      while (pwm_o[ch] == lvl && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // ends at the sample where the channel rises; h = high samples, p = period
   task automatic measure(input int ch, output int h, output int p);
      int t, l;
      count_level(ch, 1'b1, t);
      count_level(ch, 1'b0, t);
      count_level(ch, 1'b1, h);
      count_level(ch, 1'b0, l);
      p = h + l;
   endtask

   task automatic setup(input int rl, input int tap);
      wr(0, ctl(tap, 0, 0, 0));
      wr(1, rl);
   endtask

   initial begin
      int v, h, p, k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      rd(2, v); check("R10 counter", v, 0);
      rd(0, v); check("R10 control", v, 0);
      rd(1, v); check("R10 reload", v, 0);
      check("R10 outputs", int'(pwm_o), 0);
      repeat (20) @(negedge clk);
      rd(2, v); check("R10 counter idle", v, 0);

      // R1 R2 R8: period and high time table
      foreach (VEC[i]) begin
         automatic int rl  = int'(VEC[i][23:16]);
         automatic int tp  = int'(VEC[i][15:8]);
         automatic int dt  = int'(VEC[i][7:0]);
         setup(rl, tp);
         wr(3, dt);
         wr(0, ctl(tp, 1, 0, 1));
         measure(0, h, p);
         check("R2 period", p, (256 - rl) << tp);
         check("R8 high time", h, (dt - rl) << tp);
      end

      // R7: duty change waits for next overflow
      setup(8'hF0, 2);
      wr(3, 8'hF8);
      wr(0, ctl(2, 1, 0, 1));
      measure(0, h, p);
      wr(3, 8'hF4);
      count_level(0, 1'b1, h);
      check("R7 current period unchanged", h + 1, 32);
      count_level(0, 1'b0, k);
      count_level(0, 1'b1, h);
      check("R7 next period new duty", h, 16);

      // R9 R8: four channels together
      setup(8'hE0, 0);
      wr(3, 8'hE0);
      wr(4, 8'h10);
      wr(5, 8'hF0);
      wr(6, 8'hFF);
      wr(0, ctl(0, 1, 0, 1));
      repeat (80) @(negedge clk);
      k = 0;
      for (int c = 0; c < 200; c++) begin
         if (pwm_o[1:0] == 2'b11) k++;
         @(negedge clk);
      end
      check("R9 compare equals reload and below stays high", k, 200);
      measure(2, h, p);
      check("R8 ch2 high", h, 16);
      check("R2 ch2 period", p, 32);
      measure(3, h, p);
      check("R8 ch3 high", h, 31);

      // R5: counter write clears prescaler
      setup(8'h00, 2);
      wr(0, ctl(2, 1, 0, 1));
      repeat (5) @(negedge clk);
      wr(2, 8'h10);
      k = 0;
      rd(2, v);
      while (v == 8'h10 && k < 100) begin
         k++;
         @(negedge clk);
         rd(2, v);
      end
      check("R5 samples before first advance", k, 4);
      check("R5 next value", v, 8'h11);

      // R3: hold when stopped
      wr(0, ctl(2, 0, 0, 0));
      rd(2, v);
      repeat (40) @(negedge clk);
      rd(2, k);
      check("R3 counter frozen", k, v);
      wr(0, ctl(0, 1, 0, 0));
      @(negedge clk);
      rd(2, k);
      check("R3 resumes", k, (v + 1) & 8'hFF);

      // R6: force reload, bit not stored
      wr(0, ctl(0, 0, 0, 0));
      wr(1, 8'h77);
      wr(0, ctl(0, 0, 0, 1));
      rd(2, v); check("R6 counter from reload", v, 8'h77);
      rd(0, v); check("R6 strobe reads zero", v, 0);

      // R4: external source
      wr(0, ctl(0, 1, 1, 0));
      wr(2, 8'h20);
      repeat (10) @(negedge clk);
      rd(2, v); check("R4 idle pin no count", v, 8'h20);
      for (int e = 0; e < 5; e++) begin
         ext_clk_i = 1'b1; repeat (6) @(negedge clk);
         ext_clk_i = 1'b0; repeat (6) @(negedge clk);
      end
      rd(2, v); check("R4 five edges", v, 8'h25);
      ext_clk_i = 1'b1;
      repeat (20) @(negedge clk);
      rd(2, v); check("R4 held high counts once", v, 8'h26);
      rd(0, v); check("R4 control readback", v, ctl(0, 1, 1, 0));

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule